// File: doc/BRIEF.md
# Dual-Clock FIFO with Retransmit

This block is an 18-bit queue placed between two unrelated clock domains. A producer writes words on its own clock and a consumer reads them on another. The buffer is a register array whose size is set by the `DEPTH` parameter, which must be a power of two. Read and write positions cross between the domains as Gray-coded pointers through two-flop synchronizers. The block has two reset inputs, both active low and asynchronous:

- The full reset clears both pointers and re-captures the timing mode.
- The partial reset clears only the pointers and keeps the mode already captured.

There are two timing modes. In standard mode every word must be requested. In fall-through mode the head word is loaded into the output register without any request, and the two status outputs change meaning to ready indications. The consumer can rewind its read position to physical location zero and re-read from there. A separate programming block supplies the almost-full and almost-empty thresholds. Instead of a tri-state pad, an output-enable input forces the data output to zero.

Top module: `dcq_fifo`

## Requirements
- R1: A word is stored on a rising `wr_clk` edge when `wr_en_n` is low and the queue is not full. Stored words leave in the order they were written.
- R2: In standard mode, a rising `rd_clk` edge with `rd_en_n` low and the queue not empty loads the next word into `rd_data`. Without that request, `rd_data` holds its value.
- R3: In fall-through mode, the first word written reaches `rd_data` with no request, and `empty_or_outrdy` drops to 0. Each later word advances only on a request. Once the last word has been taken, `empty_or_outrdy` returns to 1.
- R4: The level of `mode_sel_in` on `wr_clk` edges while `full_rst_n` is low selects the mode: 1 gives fall-through, 0 gives standard. The selection survives a partial reset and later changes of `mode_sel_in`.
- R5: After either reset, `rd_data` reads 0, `almost_full_n` reads 1 and `almost_empty_n` reads 0. In standard mode `full_or_inrdy` reads 1 and `empty_or_outrdy` reads 0. In fall-through mode `full_or_inrdy` reads 0 and `empty_or_outrdy` reads 1.
- R6: A write while full and a read while empty are ignored. Neither pointer moves, and `rd_data` keeps its value.
- R7: In standard mode, `full_or_inrdy` is 0 exactly when `DEPTH` words are stored.
- R8: `almost_full_n` is 0 when the free space (`DEPTH` minus the stored count) is at or below `af_offset`.
- R9: `almost_empty_n` is 0 when the stored count is at or below `ae_offset`. In fall-through mode, the word held in the output register counts toward this total.
- R10: `half_n` is 0 when more than `DEPTH/2` words are stored.
- R11: A rising `rd_clk` edge with `rewind` high sets the read position to location zero. The next word read is the one written first after the last reset.
- R12: While `out_en_n` is high, `rd_data` reads 0. Queue state is unaffected, and the held word returns once `out_en_n` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-domain clock |
| rd_clk | input | 1 | Read-domain clock |
| full_rst_n | input | 1 | Full reset, active low: clears pointers and re-captures the mode |
| part_rst_n | input | 1 | Partial reset, active low: clears pointers only |
| mode_sel_in | input | 1 | Mode level sampled during full reset (1 = fall-through) |
| wr_en_n | input | 1 | Write request, active low |
| wr_data | input | DW | Word to store |
| af_offset | input | AW+1 | Almost-full threshold in free words |
| ae_offset | input | AW+1 | Almost-empty threshold in stored words |
| rd_en_n | input | 1 | Read request, active low |
| rewind | input | 1 | Retransmit: sets the read position to location zero |
| out_en_n | input | 1 | Output enable, active low; when high, rd_data reads 0 |
| rd_data | output | DW | Output word |
| full_or_inrdy | output | 1 | Standard: 0 = full. Fall-through: 0 = ready to accept |
| empty_or_outrdy | output | 1 | Standard: 0 = empty. Fall-through: 0 = word presented |
| half_n | output | 1 | 0 when more than half full |
| almost_full_n | output | 1 | 0 when free space is at or below af_offset |
| almost_empty_n | output | 1 | 0 when stored count is at or below ae_offset |

## Verification
Some behaviours are checked by assertions on every cycle:

- each Gray pointer changes by at most one bit per clock outside a rewind;
- the stored count never passes `DEPTH`;
- a blocked write or read leaves its pointer untouched;
- a rewind lands on zero;
- the output register holds steady in either mode whenever no word is taken.

Other behaviours depend on latencies across the two domains, so only directed scenarios can show them. These are the data order end to end, the exact threshold crossings of the three level flags, the mode selection surviving a partial reset, the fall-through presentation of the first word, and re-reading after a rewind.

// File: rtl/dcq_pkg.sv
package dcq_pkg;
  localparam int unsigned WORD_W = 18;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } dcq_mode_e;
endpackage

// File: rtl/dcq_ram.sv
module dcq_ram #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 4
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int unsigned WORDS = 1 << AW;

  logic [DW-1:0] cells [WORDS];

  always_ff @(posedge wclk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dcq_gray_sync.sv
module dcq_gray_sync #(
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] gray_in,
  output logic [PW-1:0] bin_out
);
  logic [PW-1:0] stage1, stage2;

  function automatic logic [PW-1:0] gray_to_bin(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = int'(PW) - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= gray_in;
      stage2 <= stage1;
    end
  end

  assign bin_out = gray_to_bin(stage2);
endmodule

// File: rtl/dcq_wr_side.sv
module dcq_wr_side #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned AW    = 4,
  parameter int unsigned PW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          wr_en_n,
  input  logic [PW-1:0] rd_bin,
  input  logic [PW-1:0] af_off,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full_or_inrdy,
  output logic          af_n,
  output logic          half_n
);
  localparam logic [PW-1:0] CAP     = PW'(DEPTH);
  localparam logic [PW-1:0] HALFWAY = PW'(DEPTH / 2);

  logic [PW-1:0] wbin, wbin_nxt, used, free;
  logic          is_full, wr_blocked;

  function automatic logic [PW-1:0] occupancy(input logic [PW-1:0] head,
                                              input logic [PW-1:0] tail);
    return head - tail;
  endfunction

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  assign used       = occupancy(wbin, rd_bin);
  assign free       = CAP - used;
  assign is_full    = (used == CAP);
  assign wr_fire    = !wr_en_n && !is_full;
  assign wr_blocked = !wr_en_n && is_full;
  assign wbin_nxt   = wbin + PW'(wr_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else begin
      wbin  <= wbin_nxt;
      wgray <= to_gray(wbin_nxt);
    end
  end

  assign waddr         = wbin[AW-1:0];
  assign full_or_inrdy = fwft ? is_full : !is_full;
  assign af_n          = !(free <= af_off);
  assign half_n        = !(used > HALFWAY);

  // R1: the crossing pointer steps by one bit at most
  a_r1_wgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(wgray ^ $past(wgray)) <= 1));

  // R6: a write refused while full leaves the crossing pointer untouched
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |=> $stable(wgray));

  // R7: occupancy seen from the write side never passes capacity
  a_r7_used_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    used <= CAP);
endmodule

// File: rtl/dcq_rd_side.sv
module dcq_rd_side #(
  parameter int unsigned DW = 18,
  parameter int unsigned AW = 4,
  parameter int unsigned PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwft,
  input  logic          rd_en_n,
  input  logic          rewind,
  input  logic [PW-1:0] wr_bin,
  input  logic [PW-1:0] ae_off,
  input  logic [DW-1:0] ram_q,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic [DW-1:0] dout,
  output logic          empty_or_outrdy,
  output logic          ae_n
);
  logic [PW-1:0] rbin, rbin_nxt, stored, level;
  logic          head_vld, ram_empty, rd_req, pull, take;

  function automatic logic [PW-1:0] to_gray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] level_of(input logic [PW-1:0] in_ram,
                                             input logic          in_reg);
    return in_ram + PW'(in_reg);
  endfunction

  assign stored    = wr_bin - rbin;
  assign ram_empty = (stored == '0);
  assign rd_req    = !rd_en_n;
  // pull: a word leaves the array into the output register
  assign pull      = fwft ? (!ram_empty && (!head_vld || rd_req))
                          : (rd_req && !ram_empty);
  // take: the consumer accepts the presented word (fall-through only)
  assign take      = rd_req && head_vld;
  assign rbin_nxt  = rewind ? '0 : rbin + PW'(pull);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      head_vld <= 1'b0;
      dout     <= '0;
    end else begin
      rbin  <= rbin_nxt;
      rgray <= to_gray(rbin_nxt);
      if (!fwft || rewind)  head_vld <= 1'b0;
      else if (pull)        head_vld <= 1'b1;
      else if (take)        head_vld <= 1'b0;
      if (pull && !rewind)  dout <= ram_q;
    end
  end

  assign raddr           = rbin[AW-1:0];
  assign level           = level_of(stored, fwft && head_vld);
  assign empty_or_outrdy = fwft ? !head_vld : !ram_empty;
  assign ae_n            = !(level <= ae_off);

  // R1: read pointer steps by one bit at most except on a rewind
  a_r1_rgray_step: assert property (@(posedge clk) disable iff (!rst_n)
    !rewind |=> ($countones(rgray ^ $past(rgray)) <= 1));

  // R6: a standard-mode read on an empty queue moves nothing
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && rd_req && ram_empty && !rewind) |=> ($stable(rbin) && $stable(dout)));

  // R11: a rewind lands on location zero
  a_r11_rewind_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rewind |=> (raddr == '0));

  // R2: standard mode holds the output while no request is made
  a_r2_std_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && rd_en_n) |=> $stable(dout));

  // R3: a presented fall-through word stays until it is taken
  a_r3_head_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && head_vld && rd_en_n && !rewind) |=> ($stable(dout) && !empty_or_outrdy));
endmodule

// File: rtl/dcq_fifo.sv
module dcq_fifo
  import dcq_pkg::*;
#(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned DW    = WORD_W,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned PW   = AW + 1
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          full_rst_n,
  input  logic          part_rst_n,
  input  logic          mode_sel_in,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic [PW-1:0] af_offset,
  input  logic [PW-1:0] ae_offset,
  input  logic          rd_en_n,
  input  logic          rewind,
  input  logic          out_en_n,
  output logic [DW-1:0] rd_data,
  output logic          full_or_inrdy,
  output logic          empty_or_outrdy,
  output logic          half_n,
  output logic          almost_full_n,
  output logic          almost_empty_n
);
  dcq_mode_e     mode_q;
  logic          fwft, ptr_rst_n, wr_fire;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, rgray, wbin_in_rd, rbin_in_wr;
  logic [DW-1:0] ram_q, dout;

  // mode is captured only while the full reset is held
  always_ff @(posedge wr_clk) begin
    if (!full_rst_n) mode_q <= mode_sel_in ? MODE_FWFT : MODE_STD;
  end

  assign fwft      = (mode_q == MODE_FWFT);
  assign ptr_rst_n = full_rst_n & part_rst_n;

  dcq_ram #(.DW(DW), .AW(AW)) u_ram (
    .wclk (wr_clk), .we (wr_fire), .waddr (waddr), .wdata (wr_data),
    .raddr (raddr), .rdata (ram_q)
  );

  dcq_gray_sync #(.PW(PW)) u_w2r (
    .clk (rd_clk), .rst_n (ptr_rst_n), .gray_in (wgray), .bin_out (wbin_in_rd)
  );

  dcq_gray_sync #(.PW(PW)) u_r2w (
    .clk (wr_clk), .rst_n (ptr_rst_n), .gray_in (rgray), .bin_out (rbin_in_wr)
  );

  dcq_wr_side #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_wr (
    .clk (wr_clk), .rst_n (ptr_rst_n), .fwft (fwft), .wr_en_n (wr_en_n),
    .rd_bin (rbin_in_wr), .af_off (af_offset), .wr_fire (wr_fire),
    .waddr (waddr), .wgray (wgray), .full_or_inrdy (full_or_inrdy),
    .af_n (almost_full_n), .half_n (half_n)
  );

  dcq_rd_side #(.DW(DW), .AW(AW), .PW(PW)) u_rd (
    .clk (rd_clk), .rst_n (ptr_rst_n), .fwft (fwft), .rd_en_n (rd_en_n),
    .rewind (rewind), .wr_bin (wbin_in_rd), .ae_off (ae_offset),
    .ram_q (ram_q), .raddr (raddr), .rgray (rgray), .dout (dout),
    .empty_or_outrdy (empty_or_outrdy), .ae_n (almost_empty_n)
  );

  assign rd_data = out_en_n ? '0 : dout;

  // R4: the captured mode never moves outside a full reset
  a_r4_mode_steady: assert property (@(posedge wr_clk) disable iff (!full_rst_n)
    $stable(mode_q));
endmodule

// File: tb/sim_dcq_fifo.sv
module sim_dcq_fifo;
  localparam int unsigned DEPTH = 16;
  localparam int unsigned DW    = 18;
  localparam int unsigned PW    = 5;

  logic          wr_clk = 1'b0, rd_clk = 1'b0;
  logic          full_rst_n = 1'b0, part_rst_n = 1'b1, mode_sel_in = 1'b0;
  logic          wr_en_n = 1'b1, rd_en_n = 1'b1, rewind = 1'b0, out_en_n = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic [PW-1:0] af_offset = 5'd2, ae_offset = 5'd3;
  logic [DW-1:0] rd_data;
  logic          full_or_inrdy, empty_or_outrdy, half_n, almost_full_n, almost_empty_n;

  int n_chk = 0;
  int n_bad = 0;

  // bit 18: 0 = write the word, 1 = read and expect the word
  localparam logic [18:0] VEC [10] = '{
    {1'b0, 18'h00011}, {1'b0, 18'h00022}, {1'b1, 18'h00011},
    {1'b0, 18'h00033}, {1'b1, 18'h00022}, {1'b1, 18'h00033},
    {1'b0, 18'h3FFFF}, {1'b0, 18'h00000}, {1'b1, 18'h3FFFF},
    {1'b1, 18'h00000}
  };

  always #10 wr_clk = ~wr_clk;
  initial begin
    #5;
    forever #10 rd_clk = ~rd_clk;
  end

  dcq_fifo #(.DEPTH(DEPTH), .DW(DW)) u0 (
    .wr_clk, .rd_clk, .full_rst_n, .part_rst_n, .mode_sel_in, .wr_en_n,
    .wr_data, .af_offset, .ae_offset, .rd_en_n, .rewind, .out_en_n,
    .rd_data, .full_or_inrdy, .empty_or_outrdy, .half_n, .almost_full_n,
    .almost_empty_n
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (5) @(negedge rd_clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    @(negedge wr_clk);
    wr_en_n = 1'b0;
    wr_data = d;
    @(negedge wr_clk);
    wr_en_n = 1'b1;
    settle();
  endtask

  task automatic pop();
    @(negedge rd_clk);
    rd_en_n = 1'b0;
    @(negedge rd_clk);
    rd_en_n = 1'b1;
  endtask

  task automatic hard_reset(input logic m);
    @(negedge wr_clk);
    full_rst_n  = 1'b0;
    mode_sel_in = m;
    repeat (3) @(negedge wr_clk);
    full_rst_n  = 1'b1;
    mode_sel_in = ~m;
    settle();
  endtask

  task automatic soft_reset();
    @(negedge wr_clk);
    part_rst_n = 1'b0;
    repeat (3) @(negedge wr_clk);
    part_rst_n = 1'b1;
    settle();
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R5: standard-mode reset state
    hard_reset(1'b0);
    chk("R5 std data", 32'(rd_data), 0);
    chk("R5 std full", 32'(full_or_inrdy), 1);
    chk("R5 std empty", 32'(empty_or_outrdy), 0);
    chk("R5 std af", 32'(almost_full_n), 1);
    chk("R5 std ae", 32'(almost_empty_n), 0);

    // R1, R2: table of writes and reads
    for (int i = 0; i < 10; i++) begin
      if (VEC[i][18] == 1'b0) push(VEC[i][17:0]);
      else begin
        pop();
        chk("R1 R2 table read", 32'(rd_data), 32'(VEC[i][17:0]));
      end
    end

    // R2: no request, output holds
    repeat (6) @(negedge rd_clk);
    chk("R2 hold", 32'(rd_data), 0);

    // R7 R8 R9 R10: fill to capacity, probe thresholds
    for (int k = 1; k <= 16; k++) begin
      push(18'(k * 3 + 1));
      if (k == 3)  chk("R9 ae at 3", 32'(almost_empty_n), 0);
      if (k == 4)  chk("R9 ae at 4", 32'(almost_empty_n), 1);
      if (k == 8)  chk("R10 half at 8", 32'(half_n), 1);
      if (k == 9)  chk("R10 half at 9", 32'(half_n), 0);
      if (k == 13) chk("R8 af free 3", 32'(almost_full_n), 1);
      if (k == 14) chk("R8 af free 2", 32'(almost_full_n), 0);
      if (k == 15) chk("R7 not full", 32'(full_or_inrdy), 1);
    end
    chk("R7 full", 32'(full_or_inrdy), 0);

    // R6: write while full is dropped
    push(18'h2AAAA);
    for (int k = 1; k <= 16; k++) begin
      pop();
      chk("R1 R6 drain order", 32'(rd_data), 32'(k * 3 + 1));
    end
    chk("R6 empty after drain", 32'(empty_or_outrdy), 0);
    pop();
    chk("R6 read while empty", 32'(rd_data), 49);
    push(18'h00ABC);
    pop();
    chk("R6 next word", 32'(rd_data), 32'h00ABC);

    // R11: rewind after partial reset
    soft_reset();
    chk("R5 part reset data", 32'(rd_data), 0);
    push(18'h0000A);
    push(18'h0000B);
    push(18'h0000C);
    pop();
    chk("R11 first", 32'(rd_data), 32'h0000A);
    pop();
    chk("R11 second", 32'(rd_data), 32'h0000B);
    @(negedge rd_clk);
    rewind = 1'b1;
    @(negedge rd_clk);
    rewind = 1'b0;
    settle();
    chk("R11 not empty", 32'(empty_or_outrdy), 1);
    pop();
    chk("R11 reread", 32'(rd_data), 32'h0000A);

    // R12: output gating
    out_en_n = 1'b1;
    #1;
    chk("R12 gated", 32'(rd_data), 0);
    repeat (3) @(negedge rd_clk);
    out_en_n = 1'b0;
    #1;
    chk("R12 restored", 32'(rd_data), 32'h0000A);

    // R4 R5 R3: fall-through mode
    hard_reset(1'b1);
    chk("R5 fwft inrdy", 32'(full_or_inrdy), 0);
    chk("R5 fwft outrdy", 32'(empty_or_outrdy), 1);
    chk("R5 fwft data", 32'(rd_data), 0);
    chk("R5 fwft ae", 32'(almost_empty_n), 0);
    push(18'h00155);
    chk("R3 first falls", 32'(rd_data), 32'h00155);
    chk("R3 outrdy", 32'(empty_or_outrdy), 0);
    push(18'h002AA);
    chk("R3 no advance", 32'(rd_data), 32'h00155);
    chk("R9 fwft count 2", 32'(almost_empty_n), 0);
    pop();
    chk("R3 next word", 32'(rd_data), 32'h002AA);
    pop();
    chk("R3 outrdy after last", 32'(empty_or_outrdy), 1);

    // R4: partial reset keeps fall-through
    soft_reset();
    chk("R4 keep inrdy", 32'(full_or_inrdy), 0);
    chk("R4 keep outrdy", 32'(empty_or_outrdy), 1);

    // R4: full reset back to standard
    hard_reset(1'b0);
    chk("R4 std full", 32'(full_or_inrdy), 1);
    chk("R4 std empty", 32'(empty_or_outrdy), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule